// File: doc/BRIEF.md
# Windowed Event Counter Bank

This block is a bank of four measurement channels that count processor activity. Each channel picks one event source from a set of per-cycle strobes: elapsed cycles, issued instructions, dual issue, branches, cache accesses, cache misses, bus requests and bus responses. A channel counts only while its measurement window is open. The window is opened and closed by event-match pulses, and each channel chooses its own opening and closing pulse. Configuration arrives as static inputs.

Adjacent channels form pairs. A pair can be cascaded so that the lower channel carries into the upper one, which gives one counter of twice the width. A counter that runs past its maximum holds at all ones and raises a sticky overflow flag, so a wrapped value is never reported as a result. An initialise strobe clears every count and flag. A clock-halt input freezes the whole bank, because counting runs on the processor clock.

Top module: `perf_window_counters`

## Requirements
- R1: After reset every count, every overflow flag and every wide output is zero, and every window is closed.
- R2: When a channel has both its start and its end condition enabled, its window opens on the clock edge that samples the selected start match pulse (`match_pulse[start_sel]`). Events are counted on each later edge while the window is open, including the edge that samples the end pulse. After that edge the window is closed.
- R3: A channel that has exactly one of its two conditions enabled never opens its window and never counts.
- R4: A channel with neither condition enabled opens on `run_start` and closes on the first permitted match pulse of any index.
- R5: When the start and end pulses are sampled on the same edge, the end pulse wins: an open window closes and a closed window stays closed.
- R6: Each channel counts the strobe selected by its own 3-bit source field, independently of the other channels. The encodings are 0 cycles, 1 issued, 2 dual issue, 3 branch, 4 cache access, 5 cache miss, 6 bus request and 7 bus response.
- R7: A branch event (source 3) adds 2 per strobe. Every other source adds 1.
- R8: While `clk_halt` is high, no count changes and no window changes state. A match pulse sampled during a halt is lost.
- R9: A channel that would exceed its maximum value (CNT_W bits, 32 by default) holds at all ones and sets its overflow flag. The flag stays set until initialise.
- R10: `init` clears all counts and overflow flags on the next edge. It does not change window state, so an open window keeps counting afterwards.
- R11: When `cascade_en[p]` is set, channels 2p and 2p+1 form one 2·CNT_W counter driven by channel 2p's window and source. The result appears on `wide_out[p]` as {upper, lower}. Channel 2p+1's own source is ignored. Overflow of the joined counter sets both flags and freezes both halves at all ones. When the pair is not cascaded, `wide_out[p]` is zero.
- R12: Only the upper-half channels (2 and 3) may use the bus sources (6 and 7) and the bus match inputs (indices 6 and 7). On channels 0 and 1, those sources count nothing and those match inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processor clock |
| rst_n | input | 1 | active-low asynchronous-free reset, sampled on clk |
| clk_halt | input | 1 | clock halted (sleep); freezes the bank |
| run_start | input | 1 | program run begins (for channels with no conditions) |
| init | input | 1 | clear all counts and overflow flags |
| evt_strobe | input | 8 | per-cycle event strobes, indexed by source code |
| match_pulse | input | NUM_MATCH | event-match pulses |
| cfg_src | input | NUM_CH*3 | source select per channel |
| cfg_start_on | input | NUM_CH | start condition enabled per channel |
| cfg_start_sel | input | NUM_CH*MSEL_W | start match index per channel |
| cfg_end_on | input | NUM_CH | end condition enabled per channel |
| cfg_end_sel | input | NUM_CH*MSEL_W | end match index per channel |
| cascade_en | input | NUM_CH/2 | join pair p into one wide counter |
| count_out | output | NUM_CH*CNT_W | per-channel counts |
| ovf_out | output | NUM_CH | sticky overflow flags |
| wide_out | output | NUM_CH*CNT_W | per-pair joined value {upper, lower} |

## Verification
Some properties are checked on every cycle. A window closes whenever an end pulse is sampled, and it stays closed while only one condition is enabled. Neither the windows nor the counts move during a halt. Overflow flags are sticky and come with an all-ones count. Initialise clears the results, and a cascaded pair steps by exactly the lower channel's increment. Other behaviour can only be shown by the bench's scenarios. These are the exact counts at each window boundary and the double weight of branches. They also include the source choice on each channel, the carry from one half of a cascaded pair into the other, and the barring of bus sources and bus matches on the lower channels.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  localparam int SRC_W   = 3;
  localparam int NUM_SRC = 8;

  typedef enum logic [SRC_W-1:0] {
    SRC_CYCLE  = 3'd0,
    SRC_ISSUE  = 3'd1,
    SRC_DUAL   = 3'd2,
    SRC_BRANCH = 3'd3,
    SRC_CACC   = 3'd4,
    SRC_CMISS  = 3'd5,
    SRC_BUSREQ = 3'd6,
    SRC_BUSRSP = 3'd7
  } src_e;

  // weight added per strobe of a source
  function automatic logic [1:0] evt_weight(input logic [SRC_W-1:0] sel);
    return (sel == SRC_BRANCH) ? 2'd2 : 2'd1;
  endfunction

  // sources that only the upper-half channels may count
  function automatic logic src_is_bus(input logic [SRC_W-1:0] sel);
    return (sel == SRC_BUSREQ) || (sel == SRC_BUSRSP);
  endfunction

endpackage

// File: rtl/pwc_window.sv
module pwc_window #(
  parameter int NUM_MATCH    = 8,
  parameter int BUS_MATCH_LO = 6,
  parameter bit BUS_OK       = 1'b0,
  localparam int MSEL_W      = $clog2(NUM_MATCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt,
  input  logic                 run_start,
  input  logic [NUM_MATCH-1:0] match_pulse,
  input  logic                 start_on,
  input  logic [MSEL_W-1:0]    start_sel,
  input  logic                 end_on,
  input  logic [MSEL_W-1:0]    end_sel,
  output logic                 active
);

  logic [NUM_MATCH-1:0] perm_mask;
  logic [NUM_MATCH-1:0] allowed;
  logic                 both_cfg;
  logic                 none_cfg;
  logic                 start_hit;
  logic                 end_hit;
  logic                 win_q;

  always_comb begin
    for (int k = 0; k < NUM_MATCH; k++) begin
      perm_mask[k] = BUS_OK || (k < BUS_MATCH_LO);
    end
  end

  assign allowed   = match_pulse & perm_mask;
  assign both_cfg  = start_on & end_on;
  assign none_cfg  = ~start_on & ~end_on;
  assign start_hit = both_cfg ? allowed[start_sel] : (none_cfg & run_start);
  assign end_hit   = both_cfg ? allowed[end_sel]   : (none_cfg & (|allowed));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= 1'b0;
    end else if (!halt) begin
      if (!(both_cfg || none_cfg)) win_q <= 1'b0;
      else if (end_hit)            win_q <= 1'b0;
      else if (start_hit)          win_q <= 1'b1;
    end
  end

  assign active = win_q;

  // R3: a half-configured channel holds its window shut
  p_half_cfg_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && (start_on ^ end_on)) |=> !win_q);

  // R5: an end pulse always leaves the window closed
  p_end_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && end_hit) |=> !win_q);

  // R8: window state frozen while the clock is halted
  p_halt_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(win_q));

endmodule

// File: rtl/pwc_evt_pick.sv
module pwc_evt_pick
  import pwc_pkg::*;
#(
  parameter bit BUS_OK = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] strobe,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic               active,
  input  logic               halt,
  output logic [1:0]         inc
);

  logic src_ok;
  logic picked;

  assign src_ok = BUS_OK || !src_is_bus(src_sel);
  assign picked = strobe[src_sel];
  assign inc    = (active && !halt && src_ok && picked) ? evt_weight(src_sel) : 2'd0;

  // R7: a double step only comes from the branch source
  p_double_only_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == 2'd2) |-> (src_sel == SRC_BRANCH));

  // R2: nothing is counted outside an open window
  p_closed_no_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (inc == 2'd0));

endmodule

// File: rtl/pwc_pair_acc.sv
module pwc_pair_acc #(
  parameter int CNT_W = 32,
  localparam int WW   = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             casc,
  input  logic [1:0]       inc_lo,
  input  logic [1:0]       inc_hi,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic             ovf_lo,
  output logic             ovf_hi,
  output logic [WW-1:0]    wide
);

  function automatic logic [CNT_W:0] add_narrow(input logic [CNT_W-1:0] v, input logic [1:0] d);
    return {1'b0, v} + {{(CNT_W-1){1'b0}}, d};
  endfunction

  function automatic logic [WW:0] add_wide(input logic [WW-1:0] v, input logic [1:0] d);
    return {1'b0, v} + {{(WW-1){1'b0}}, d};
  endfunction

  logic [CNT_W:0] sum_lo;
  logic [CNT_W:0] sum_hi;
  logic [WW:0]    sum_wide;
  logic           lo_carry;
  logic           hi_carry;
  logic           wide_carry;
  logic           pair_frozen;

  assign sum_lo      = add_narrow(cnt_lo, inc_lo);
  assign sum_hi      = add_narrow(cnt_hi, inc_hi);
  assign sum_wide    = add_wide({cnt_hi, cnt_lo}, inc_lo);
  assign lo_carry    = sum_lo[CNT_W];
  assign hi_carry    = sum_hi[CNT_W];
  assign wide_carry  = sum_wide[WW];
  assign pair_frozen = ovf_lo | ovf_hi;

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      ovf_lo <= 1'b0;
      ovf_hi <= 1'b0;
    end else if (casc) begin
      if (!pair_frozen) begin
        if (wide_carry) begin
          cnt_lo <= '1;
          cnt_hi <= '1;
          ovf_lo <= 1'b1;
          ovf_hi <= 1'b1;
        end else begin
          {cnt_hi, cnt_lo} <= sum_wide[WW-1:0];
        end
      end
    end else begin
      if (!ovf_lo) begin
        if (lo_carry) begin
          cnt_lo <= '1;
          ovf_lo <= 1'b1;
        end else begin
          cnt_lo <= sum_lo[CNT_W-1:0];
        end
      end
      if (!ovf_hi) begin
        if (hi_carry) begin
          cnt_hi <= '1;
          ovf_hi <= 1'b1;
        end else begin
          cnt_hi <= sum_hi[CNT_W-1:0];
        end
      end
    end
  end

  assign wide = casc ? {cnt_hi, cnt_lo} : '0;

  // R9: overflow flags are sticky until initialise
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_lo || ovf_hi) && !init) |=> (($past(ovf_lo) -> ovf_lo) && ($past(ovf_hi) -> ovf_hi)));

  // R9: a flagged channel shows all ones
  p_ovf_all_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_lo |-> (cnt_lo == '1)) and (ovf_hi |-> (cnt_hi == '1)));

  // R10: initialise leaves a clean channel pair
  p_init_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (cnt_lo == '0 && cnt_hi == '0 && !ovf_lo && !ovf_hi));

  // R11: a joined pair advances by exactly the lower increment
  p_wide_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !init && !pair_frozen && !wide_carry) |=>
      ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + WW'($past(inc_lo))));

endmodule

// File: rtl/perf_window_counters.sv
module perf_window_counters
  import pwc_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int CNT_W        = 32,
  parameter int NUM_MATCH    = 8,
  parameter int BUS_MATCH_LO = 6,
  localparam int MSEL_W      = $clog2(NUM_MATCH),
  localparam int NUM_PAIRS   = NUM_CH / 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clk_halt,
  input  logic                        run_start,
  input  logic                        init,
  input  logic [NUM_SRC-1:0]          evt_strobe,
  input  logic [NUM_MATCH-1:0]        match_pulse,
  input  logic [NUM_CH*SRC_W-1:0]     cfg_src,
  input  logic [NUM_CH-1:0]           cfg_start_on,
  input  logic [NUM_CH*MSEL_W-1:0]    cfg_start_sel,
  input  logic [NUM_CH-1:0]           cfg_end_on,
  input  logic [NUM_CH*MSEL_W-1:0]    cfg_end_sel,
  input  logic [NUM_PAIRS-1:0]        cascade_en,
  output logic [NUM_CH*CNT_W-1:0]     count_out,
  output logic [NUM_CH-1:0]           ovf_out,
  output logic [NUM_PAIRS*2*CNT_W-1:0] wide_out
);

  logic [NUM_CH-1:0] ch_active;
  logic [1:0]        ch_inc [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam bit UPPER = (i >= NUM_CH / 2);

    pwc_window #(
      .NUM_MATCH    (NUM_MATCH),
      .BUS_MATCH_LO (BUS_MATCH_LO),
      .BUS_OK       (UPPER)
    ) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt        (clk_halt),
      .run_start   (run_start),
      .match_pulse (match_pulse),
      .start_on    (cfg_start_on[i]),
      .start_sel   (cfg_start_sel[i*MSEL_W +: MSEL_W]),
      .end_on      (cfg_end_on[i]),
      .end_sel     (cfg_end_sel[i*MSEL_W +: MSEL_W]),
      .active      (ch_active[i])
    );

    pwc_evt_pick #(
      .BUS_OK (UPPER)
    ) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (evt_strobe),
      .src_sel (cfg_src[i*SRC_W +: SRC_W]),
      .active  (ch_active[i]),
      .halt    (clk_halt),
      .inc     (ch_inc[i])
    );
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pwc_pair_acc #(
      .CNT_W (CNT_W)
    ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (init),
      .casc   (cascade_en[p]),
      .inc_lo (ch_inc[2*p]),
      .inc_hi (ch_inc[2*p+1]),
      .cnt_lo (count_out[(2*p)*CNT_W +: CNT_W]),
      .cnt_hi (count_out[(2*p+1)*CNT_W +: CNT_W]),
      .ovf_lo (ovf_out[2*p]),
      .ovf_hi (ovf_out[2*p+1]),
      .wide   (wide_out[p*2*CNT_W +: 2*CNT_W])
    );
  end

  // R8: halted clock leaves every count untouched
  p_halt_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_halt && !init) |=> $stable(count_out));

endmodule

// File: tb/perf_window_counters_tb.sv
module perf_window_counters_tb;

  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int NM  = 8;
  localparam int MW  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              clk_halt;
  logic              run_start;
  logic              init;
  logic [7:0]        evt_strobe;
  logic [NM-1:0]     match_pulse;
  logic [NCH*3-1:0]  cfg_src;
  logic [NCH-1:0]    cfg_start_on;
  logic [NCH*MW-1:0] cfg_start_sel;
  logic [NCH-1:0]    cfg_end_on;
  logic [NCH*MW-1:0] cfg_end_sel;
  logic [1:0]        cascade_en;
  logic [NCH*CW-1:0] count_out;
  logic [NCH-1:0]    ovf_out;
  logic [4*CW-1:0]   wide_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  perf_window_counters #(
    .NUM_CH (NCH), .CNT_W (CW), .NUM_MATCH (NM), .BUS_MATCH_LO (6)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .clk_halt (clk_halt), .run_start (run_start),
    .init (init), .evt_strobe (evt_strobe), .match_pulse (match_pulse),
    .cfg_src (cfg_src), .cfg_start_on (cfg_start_on), .cfg_start_sel (cfg_start_sel),
    .cfg_end_on (cfg_end_on), .cfg_end_sel (cfg_end_sel), .cascade_en (cascade_en),
    .count_out (count_out), .ovf_out (ovf_out), .wide_out (wide_out)
  );

  function automatic int cnt(int ch);
    return int'(count_out[ch*CW +: CW]);
  endfunction

  function automatic int wide(int p);
    return int'(wide_out[p*2*CW +: 2*CW]);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ch(int ch, int src, bit son, int ssel, bit eon, int esel);
    cfg_src[ch*3 +: 3]        = 3'(src);
    cfg_start_on[ch]          = son;
    cfg_start_sel[ch*MW +: MW] = MW'(ssel);
    cfg_end_on[ch]            = eon;
    cfg_end_sel[ch*MW +: MW]  = MW'(esel);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; clk_halt = 1'b0; run_start = 1'b0; init = 1'b0;
    evt_strobe = '0; match_pulse = '0; cascade_en = '0;
    cfg_src = '0; cfg_start_on = '0; cfg_start_sel = '0; cfg_end_on = '0; cfg_end_sel = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // start pulse, n counting edges, end pulse (counted), settle
  task automatic run_window(int s, int e, int n);
    match_pulse[s] = 1'b1;
    @(negedge clk);
    match_pulse[s] = 1'b0;
    repeat (n) @(negedge clk);
    match_pulse[e] = 1'b1;
    @(negedge clk);
    match_pulse[e] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    for (int c = 0; c < NCH; c++) chk("R1 count", cnt(c), 0);
    chk("R1 ovf", int'(ovf_out), 0);
    chk("R1 wide", wide(0) + wide(1), 0);
  endtask

  task automatic t_window();
    do_reset();
    set_ch(0, 0, 1, 0, 1, 1);
    evt_strobe = 8'h01;
    run_window(0, 1, 10);
    chk("R2 window count", cnt(0), 11);
    repeat (5) @(negedge clk);
    chk("R2 closed after end", cnt(0), 11);
  endtask

  task automatic t_one_sided();
    do_reset();
    set_ch(0, 0, 1, 0, 0, 1);
    set_ch(1, 0, 0, 0, 1, 1);
    evt_strobe = 8'h01;
    run_window(0, 1, 6);
    chk("R3 start only", cnt(0), 0);
    chk("R3 end only", cnt(1), 0);
  endtask

  task automatic t_free_run();
    do_reset();
    set_ch(0, 0, 0, 0, 0, 0);
    evt_strobe = 8'h01;
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    repeat (7) @(negedge clk);
    match_pulse[2] = 1'b1;
    @(negedge clk);
    match_pulse[2] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 run-start window", cnt(0), 8);
  endtask

  task automatic t_same_cycle();
    do_reset();
    set_ch(0, 0, 1, 0, 1, 1);
    evt_strobe = 8'h01;
    match_pulse = 8'h03;
    @(negedge clk);
    match_pulse = '0;
    repeat (5) @(negedge clk);
    chk("R5 closed stays closed", cnt(0), 0);
    match_pulse[0] = 1'b1;
    @(negedge clk);
    match_pulse[0] = 1'b0;
    repeat (4) @(negedge clk);
    match_pulse = 8'h03;
    @(negedge clk);
    match_pulse = '0;
    repeat (4) @(negedge clk);
    chk("R5 open closes", cnt(0), 5);
  endtask

  task automatic t_sources();
    do_reset();
    set_ch(0, 0, 1, 0, 1, 1);
    set_ch(1, 2, 1, 0, 1, 1);
    set_ch(2, 1, 1, 0, 1, 1);
    set_ch(3, 4, 1, 0, 1, 1);
    evt_strobe = 8'h03;
    run_window(0, 1, 9);
    chk("R6 ch0 cycles", cnt(0), 10);
    chk("R6 ch1 dual idle", cnt(1), 0);
    chk("R6 ch2 issued", cnt(2), 10);
    chk("R6 ch3 cache idle", cnt(3), 0);
  endtask

  task automatic t_branch();
    do_reset();
    set_ch(0, 3, 1, 0, 1, 1);
    evt_strobe = 8'h08;
    run_window(0, 1, 5);
    chk("R7 branch weight", cnt(0), 12);
  endtask

  task automatic t_halt();
    do_reset();
    set_ch(0, 0, 1, 0, 1, 1);
    evt_strobe = 8'h01;
    match_pulse[0] = 1'b1;
    @(negedge clk);
    match_pulse[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 before halt", cnt(0), 4);
    clk_halt = 1'b1;
    match_pulse[1] = 1'b1;
    @(negedge clk);
    match_pulse[1] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 frozen", cnt(0), 4);
    clk_halt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 end pulse lost", cnt(0), 7);
  endtask

  task automatic t_overflow_init();
    do_reset();
    set_ch(0, 0, 1, 0, 1, 1);
    evt_strobe = 8'h01;
    match_pulse[0] = 1'b1;
    @(negedge clk);
    match_pulse[0] = 1'b0;
    repeat (300) @(negedge clk);
    chk("R9 saturated", cnt(0), 255);
    chk("R9 flag", int'(ovf_out[0]), 1);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk("R10 count cleared", cnt(0), 0);
    chk("R10 flag cleared", int'(ovf_out[0]), 0);
    repeat (3) @(negedge clk);
    chk("R10 window kept", cnt(0), 3);
  endtask

  task automatic t_cascade();
    do_reset();
    cascade_en = 2'b01;
    set_ch(0, 0, 1, 0, 1, 1);
    set_ch(1, 0, 1, 0, 1, 1);
    set_ch(2, 0, 1, 0, 1, 1);
    evt_strobe = 8'h01;
    run_window(0, 1, 299);
    chk("R11 lower half", cnt(0), 44);
    chk("R11 upper half", cnt(1), 1);
    chk("R11 wide value", wide(0), 300);
    chk("R11 uncascaded wide zero", wide(1), 0);
    chk("R11 uncascaded saturates", cnt(2), 255);
    do_reset();
    cascade_en = 2'b01;
    set_ch(0, 3, 1, 0, 1, 1);
    evt_strobe = 8'h08;
    match_pulse[0] = 1'b1;
    @(negedge clk);
    match_pulse[0] = 1'b0;
    repeat (32800) @(negedge clk);
    chk("R11 wide overflow value", wide(0), 65535);
    chk("R11 both flags", int'(ovf_out[1:0]), 3);
  endtask

  task automatic t_bus();
    do_reset();
    set_ch(0, 6, 1, 0, 1, 1);
    set_ch(2, 6, 1, 0, 1, 1);
    evt_strobe = 8'h41;
    run_window(0, 1, 6);
    chk("R12 lower bus source", cnt(0), 0);
    chk("R12 upper bus source", cnt(2), 7);
    do_reset();
    set_ch(1, 0, 1, 6, 1, 7);
    set_ch(3, 0, 1, 6, 1, 7);
    evt_strobe = 8'h01;
    run_window(6, 7, 6);
    chk("R12 lower bus match", cnt(1), 0);
    chk("R12 upper bus match", cnt(3), 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_window();
    t_one_sided();
    t_free_run();
    t_same_cycle();
    t_sources();
    t_branch();
    t_halt();
    t_overflow_init();
    t_cascade();
    t_bus();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule